// File: doc/BRIEF.md
# Frame-Difference Complexity Estimator

This block measures how hard a video frame will be to code. It does this before the frame enters the coding loop and without any result from motion search. It takes a raster stream of co-located luma samples from the current frame and the reference frame. For every pixel it forms the difference between the two samples. The stream is cut into regions of sixteen consecutive pixels on one scanline. For each region the block computes the mean difference and the total absolute deviation of the region's differences from that mean. The product of the mean's magnitude and the deviation is summed over the whole frame. This sum is the raw complexity.

At the end of each frame the block reports the raw complexity. It also reports a scaled estimate in the units of a motion-compensated sum of absolute differences: the raw value is multiplied by an integer gain and shifted right by sixteen. The gain learns from a feedback strobe after each frame. For an inter frame the feedback carries the true SAD. For an intra frame it carries the target and the true bit counts. For intra frames the block works on raw current luma instead of differences and keeps a separate gain.

On inter frames the block also raises a scene-cut flag when the raw complexity is above a programmable threshold. The flag is held back until a programmable number of frames have passed since the last intra frame or the last cut.

Top module: `cx_estimator`

## Requirements
- R1: When a frame starts with `intra_mode` low (the mode is sampled with the start-of-frame pixel), the per-pixel value is the signed 9-bit `cur_luma - ref_luma`. When it starts with `intra_mode` high, the value is `cur_luma` zero-extended and `ref_luma` is ignored.
- R2: Regions are groups of 16 consecutive valid pixels, counted from the start-of-frame pixel. A region's mean is floor(sum/16) (arithmetic shift right by 4). Its deviation is the sum of |value - mean| over its 16 pixels.
- R3: The raw complexity is the sum over the frame's regions of |mean| × deviation. It restarts at each start-of-frame pixel. It appears on `chi_raw` when `done` is high. `done` is high for exactly one cycle and rises on the second clock edge after the edge that captures the end-of-frame pixel.
- R4: The raw complexity accumulator saturates at 2^CHI_W - 1 instead of wrapping.
- R5: `est_sad` = floor(gain × chi / 65536). The gain is the inter gain for inter frames and the intra gain for intra frames. Both gains reset to 65536.
- R6: A feedback strobe after an inter frame sets the inter gain to floor(fb_true × 65536 / chi) of that frame, saturated to 2^24 - 1. The update is skipped when that chi is zero. The new gain is in use within 60 cycles.
- R7: A feedback strobe after an intra frame sets the intra gain to floor(gain × fb_target / fb_true), saturated to 2^24 - 1. The update is skipped when `fb_true` is zero.
- R8: With `done`, `scene_cut` is 1 only for an inter frame whose chi is strictly greater than `scene_thr`, and whose gap count is at least `min_gap`. The gap count is the number of frames completed since the last intra frame or flagged frame. It saturates at 255 and starts at 255 after reset.
- R9: After reset `done`, `chi_raw`, `est_sad` and `scene_cut` are zero. The outputs change only on the edge that raises `done` and hold between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel pair present this cycle |
| pix_sof | input | 1 | First pixel of a frame (with pix_valid) |
| pix_eof | input | 1 | Last pixel of a frame (with pix_valid) |
| cur_luma | input | 8 | Current-frame luma sample |
| ref_luma | input | 8 | Reference-frame luma sample |
| intra_mode | input | 1 | Frame is intra coded (sampled with pix_sof) |
| scene_thr | input | CHI_W | Scene-cut threshold on raw complexity |
| min_gap | input | 8 | Minimum frame distance before a new cut |
| fb_valid | input | 1 | Feedback strobe for the last completed frame |
| fb_true | input | 32 | True SAD (inter) or true bits (intra) |
| fb_target | input | 32 | Target bits (intra only) |
| done | output | 1 | Frame result valid pulse |
| chi_raw | output | CHI_W | Raw complexity of the last frame |
| est_sad | output | CHI_W+8 | Scaled complexity estimate |
| scene_cut | output | 1 | Scene change detected on the last frame |

## Verification
The checks assume that frames hold a whole number of 16-pixel regions, that at least three idle cycles separate an end-of-frame pixel from the next start-of-frame pixel, and that `scene_thr` and `intra_mode` stay steady during a frame. The stimulus sends 64-pixel frames with idle gaps in between and changes the threshold only between frames. Feedback strobes are sent only after a frame has completed and are spaced well beyond the divider's latency. A second instance with a narrow accumulator takes the same stream so that saturation is reached.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int LUMA_W = 8;
  localparam int DIFF_W = LUMA_W + 1;

  typedef enum logic {
    GSEL_INTER = 1'b0,
    GSEL_INTRA = 1'b1
  } gain_sel_e;
endpackage

// File: rtl/cx_region_buf.sv
// Collects one region of pixel values; pulses full when the last one lands.
module cx_region_buf
  import cx_pkg::*;
#(
  parameter int M_LOG2 = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic                         first,
  input  logic [DIFF_W-1:0]            din,
  output logic [(1<<M_LOG2)-1:0][DIFF_W-1:0] taps,
  output logic                         full
);
  localparam int M = 1 << M_LOG2;

  logic [M_LOG2-1:0] idx_q, idx_nxt, eff_idx;
  logic              full_nxt;
  logic [M-1:0][DIFF_W-1:0] taps_nxt;

  always_comb begin
    eff_idx  = first ? '0 : idx_q;
    idx_nxt  = idx_q;
    full_nxt = 1'b0;
    taps_nxt = taps;
    if (wr) begin
      taps_nxt[eff_idx] = din;
      idx_nxt           = eff_idx + 1'b1;
      full_nxt          = (eff_idx == M_LOG2'(M - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      full  <= 1'b0;
      taps  <= '0;
    end else begin
      idx_q <= idx_nxt;
      full  <= full_nxt;
      taps  <= taps_nxt;
    end
  end
endmodule

// File: rtl/cx_region_stat.sv
// Mean, absolute deviation and |mean| x deviation of one full region.
module cx_region_stat
  import cx_pkg::*;
#(
  parameter int M_LOG2 = 4,
  localparam int PROD_W = DIFF_W + DIFF_W + 1 + M_LOG2
) (
  input  logic [(1<<M_LOG2)-1:0][DIFF_W-1:0] taps,
  output logic [PROD_W-1:0]                  prod
);
  localparam int M     = 1 << M_LOG2;
  localparam int SUM_W = DIFF_W + M_LOG2;
  localparam int DEV_W = DIFF_W + 1 + M_LOG2;

  logic signed [SUM_W-1:0]  sum;
  logic signed [DIFF_W-1:0] mean;
  logic [M_LOG2-1:0]        unused_frac;
  logic [DIFF_W-1:0]        abs_mean;
  logic [DEV_W-1:0]         dev;
  logic signed [DIFF_W:0]   dk;
  logic [DIFF_W:0]          ak;

  always_comb begin
    sum = '0;
    for (int k = 0; k < M; k++) begin
      sum = sum + $signed({{M_LOG2{taps[k][DIFF_W-1]}}, taps[k]});
    end
    {mean, unused_frac} = sum;
    abs_mean = mean[DIFF_W-1] ? (~mean + 1'b1) : mean;
    dev = '0;
    dk  = '0;
    ak  = '0;
    for (int k = 0; k < M; k++) begin
      dk  = $signed({taps[k][DIFF_W-1], taps[k]}) - $signed({mean[DIFF_W-1], mean});
      ak  = dk[DIFF_W] ? (~dk + 1'b1) : dk;
      dev = dev + DEV_W'(ak);
    end
    prod = PROD_W'(abs_mean) * PROD_W'(dev);
  end
endmodule

// File: rtl/cx_gain_div.sv
// Restoring divider, one quotient bit per cycle.
module cx_gain_div #(
  parameter int NUM_W = 56,
  parameter int DEN_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W);

  logic             busy_nxt, done_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [DEN_W-1:0] rem_q, rem_nxt, den_q, den_nxt;
  logic [NUM_W-1:0] qn_q, qn_nxt;
  logic [DEN_W:0]   trial;
  logic             ge;

  always_comb begin
    busy_nxt = busy;
    done_nxt = 1'b0;
    cnt_nxt  = cnt_q;
    rem_nxt  = rem_q;
    den_nxt  = den_q;
    qn_nxt   = qn_q;
    trial    = {rem_q, qn_q[NUM_W-1]};
    ge       = (trial >= {1'b0, den_q});
    if (!busy && start) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
      rem_nxt  = '0;
      den_nxt  = den;
      qn_nxt   = num;
    end else if (busy) begin
      rem_nxt = ge ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
      qn_nxt  = {qn_q[NUM_W-2:0], ge};
      cnt_nxt = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      qn_q  <= '0;
    end else begin
      busy  <= busy_nxt;
      done  <= done_nxt;
      cnt_q <= cnt_nxt;
      rem_q <= rem_nxt;
      den_q <= den_nxt;
      qn_q  <= qn_nxt;
    end
  end

  assign quot = qn_q;
endmodule

// File: rtl/cx_estimator.sv
// Frame complexity estimator: region statistics, frame sum, gain scaling,
// scene-cut decision and per-frame gain refinement.
module cx_estimator
  import cx_pkg::*;
#(
  parameter int M_LOG2 = 4,
  parameter int CHI_W  = 40,
  parameter int GAIN_W = 24,
  parameter int SHIFT  = 16,
  parameter int TRUE_W = 32,
  parameter int GAP_W  = 8,
  localparam int EST_W = CHI_W + GAIN_W - SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic              pix_eof,
  input  logic [LUMA_W-1:0] cur_luma,
  input  logic [LUMA_W-1:0] ref_luma,
  input  logic              intra_mode,
  input  logic [CHI_W-1:0]  scene_thr,
  input  logic [GAP_W-1:0]  min_gap,
  input  logic              fb_valid,
  input  logic [TRUE_W-1:0] fb_true,
  input  logic [TRUE_W-1:0] fb_target,
  output logic              done,
  output logic [CHI_W-1:0]  chi_raw,
  output logic [EST_W-1:0]  est_sad,
  output logic              scene_cut
);
  localparam int PROD_W = DIFF_W + DIFF_W + 1 + M_LOG2;
  localparam int ACC_W  = ((CHI_W > PROD_W) ? CHI_W : PROD_W) + 1;
  localparam int NUM_A  = TRUE_W + SHIFT;
  localparam int NUM_B  = GAIN_W + TRUE_W;
  localparam int NUM_W  = (NUM_A > NUM_B) ? NUM_A : NUM_B;
  localparam int DEN_W  = (CHI_W > TRUE_W) ? CHI_W : TRUE_W;
  localparam int MUL_W  = CHI_W + GAIN_W;
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << SHIFT;

  // ---------------- pixel front end ----------------
  logic              acc_clear, frame_intra_q, frame_intra_nxt, intra_now;
  logic [DIFF_W-1:0] pix_val;
  logic [(1<<M_LOG2)-1:0][DIFF_W-1:0] taps;
  logic              region_full;
  logic [PROD_W-1:0] region_prod;

  assign acc_clear = pix_valid && pix_sof;
  assign intra_now = acc_clear ? intra_mode : frame_intra_q;
  assign pix_val   = intra_now ? {1'b0, cur_luma}
                               : ({1'b0, cur_luma} - {1'b0, ref_luma});

  cx_region_buf #(.M_LOG2(M_LOG2)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(pix_valid), .first(acc_clear),
    .din(pix_val), .taps(taps), .full(region_full)
  );

  cx_region_stat #(.M_LOG2(M_LOG2)) u_stat (
    .taps(taps), .prod(region_prod)
  );

  // ---------------- frame accumulation and results ----------------
  logic [CHI_W-1:0]  chi_q, chi_nxt, chi_base;
  logic [ACC_W-1:0]  acc_sum;
  logic              eof_q, fin_q;
  logic [GAIN_W-1:0] gain_inter_q, gain_intra_q, gain_inter_nxt, gain_intra_nxt;
  logic [GAIN_W-1:0] gain_pick;
  logic [MUL_W-1:0]  est_full;
  logic [EST_W-1:0]  est_val;
  logic [SHIFT-1:0]  unused_est_lo;
  logic [GAP_W-1:0]  gap_q, gap_nxt;
  logic              cut_now;
  logic              done_nxt, cut_nxt;
  logic [CHI_W-1:0]  chi_raw_nxt, last_chi_q, last_chi_nxt;
  logic [EST_W-1:0]  est_nxt;
  logic              last_intra_q, last_intra_nxt;

  // ---------------- gain refinement ----------------
  logic              div_start, div_busy, div_done;
  logic [NUM_W-1:0]  div_num, div_quot;
  logic [DEN_W-1:0]  div_den;
  logic [GAIN_W-1:0] quot_sat;
  gain_sel_e         tgt_q, tgt_nxt;

  assign gain_pick = frame_intra_q ? gain_intra_q : gain_inter_q;
  assign est_full  = MUL_W'(chi_q) * MUL_W'(gain_pick);
  assign {est_val, unused_est_lo} = est_full;
  assign cut_now   = !frame_intra_q && (chi_q > scene_thr) && (gap_q >= min_gap);

  assign div_den   = last_intra_q ? DEN_W'(fb_true) : DEN_W'(last_chi_q);
  assign div_num   = last_intra_q ? (NUM_W'(gain_intra_q) * NUM_W'(fb_target))
                                  : NUM_W'({fb_true, {SHIFT{1'b0}}});
  assign div_start = fb_valid && !div_busy && (div_den != '0);
  assign quot_sat  = (|div_quot[NUM_W-1:GAIN_W]) ? '1 : div_quot[GAIN_W-1:0];

  cx_gain_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_comb begin
    frame_intra_nxt = acc_clear ? intra_mode : frame_intra_q;

    chi_base = acc_clear ? '0 : chi_q;
    acc_sum  = ACC_W'(chi_base) + ACC_W'(region_prod);
    chi_nxt  = chi_base;
    if (region_full) begin
      chi_nxt = (|acc_sum[ACC_W-1:CHI_W]) ? '1 : acc_sum[CHI_W-1:0];
    end

    done_nxt       = fin_q;
    chi_raw_nxt    = chi_raw;
    est_nxt        = est_sad;
    cut_nxt        = scene_cut;
    gap_nxt        = gap_q;
    last_chi_nxt   = last_chi_q;
    last_intra_nxt = last_intra_q;
    if (fin_q) begin
      chi_raw_nxt    = chi_q;
      est_nxt        = est_val;
      cut_nxt        = cut_now;
      last_chi_nxt   = chi_q;
      last_intra_nxt = frame_intra_q;
      if (frame_intra_q || cut_now) gap_nxt = '0;
      else if (!(&gap_q))          gap_nxt = gap_q + 1'b1;
    end

    tgt_nxt = tgt_q;
    if (div_start) tgt_nxt = last_intra_q ? GSEL_INTRA : GSEL_INTER;

    gain_inter_nxt = gain_inter_q;
    gain_intra_nxt = gain_intra_q;
    if (div_done) begin
      if (tgt_q == GSEL_INTRA) gain_intra_nxt = quot_sat;
      else                     gain_inter_nxt = quot_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_intra_q <= 1'b0;
      chi_q         <= '0;
      eof_q         <= 1'b0;
      fin_q         <= 1'b0;
      done          <= 1'b0;
      chi_raw       <= '0;
      est_sad       <= '0;
      scene_cut     <= 1'b0;
      gap_q         <= '1;
      last_chi_q    <= '0;
      last_intra_q  <= 1'b0;
      tgt_q         <= GSEL_INTER;
      gain_inter_q  <= GAIN_ONE;
      gain_intra_q  <= GAIN_ONE;
    end else begin
      frame_intra_q <= frame_intra_nxt;
      chi_q         <= chi_nxt;
      eof_q         <= pix_valid && pix_eof;
      fin_q         <= eof_q;
      done          <= done_nxt;
      chi_raw       <= chi_raw_nxt;
      est_sad       <= est_nxt;
      scene_cut     <= cut_nxt;
      gap_q         <= gap_nxt;
      last_chi_q    <= last_chi_nxt;
      last_intra_q  <= last_intra_nxt;
      tgt_q         <= tgt_nxt;
      gain_inter_q  <= gain_inter_nxt;
      gain_intra_q  <= gain_intra_nxt;
    end
  end
endmodule

// File: rtl/cx_estimator_chk.sv
module cx_estimator_chk #(
  parameter int CHI_W = 40,
  parameter int EST_W = 48,
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             scene_cut,
  input logic [CHI_W-1:0] chi_raw,
  input logic [CHI_W-1:0] scene_thr,
  input logic [EST_W-1:0] est_sad,
  input logic [CHI_W-1:0] chi_q,
  input logic             region_full,
  input logic             acc_clear,
  input logic [GAP_W-1:0] gap_q
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  cut_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && scene_cut) |-> (chi_raw > scene_thr));

  // R8
  cut_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && scene_cut) |-> (gap_q == '0));

  // R4
  acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_full && !acc_clear) |=> (chi_q >= $past(chi_q)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(chi_raw) && $stable(est_sad) && $stable(scene_cut)));
endmodule

bind cx_estimator cx_estimator_chk #(
  .CHI_W(CHI_W), .EST_W(EST_W), .GAP_W(GAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .scene_cut(scene_cut),
  .chi_raw(chi_raw), .scene_thr(scene_thr), .est_sad(est_sad),
  .chi_q(chi_q), .region_full(region_full), .acc_clear(acc_clear),
  .gap_q(gap_q)
);

// File: tb/cx_estimator_test.sv
module cx_estimator_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NPIX       = 64;
  localparam int  NVEC       = 6;
  // each vector: {cur_base, cur_step, ref_base, ref_step, intra}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd10,  8'd3,   8'd0,   8'd0,  8'd1},
    {8'd50,  8'd0,   8'd50,  8'd0,  8'd0},
    {8'd200, 8'd1,   8'd20,  8'd5,  8'd0},
    {8'd0,   8'd7,   8'd128, 8'd9,  8'd0},
    {8'd30,  8'd2,   8'd30,  8'd3,  8'd0},
    {8'd255, 8'd255, 8'd0,   8'd17, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pix_valid, pix_sof, pix_eof, intra_mode, fb_valid;
  logic [7:0]  cur_luma, ref_luma;
  logic [39:0] scene_thr;
  logic [7:0]  min_gap;
  logic [31:0] fb_true, fb_target;
  logic        done, scene_cut, done_s, cut_s;
  logic [39:0] chi_raw;
  logic [47:0] est_sad;
  logic [15:0] chi_s;
  logic [23:0] est_s;

  int nchk = 0, nerr = 0;
  longint g_inter = 65536, g_intra = 65536, last_chi = 0;
  int gap_m = 255;
  bit last_intra = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cx_estimator uut (
    .clk, .rst_n, .pix_valid, .pix_sof, .pix_eof, .cur_luma, .ref_luma,
    .intra_mode, .scene_thr, .min_gap, .fb_valid, .fb_true, .fb_target,
    .done, .chi_raw, .est_sad, .scene_cut
  );

  cx_estimator #(.CHI_W(16)) uut_sat (
    .clk, .rst_n, .pix_valid, .pix_sof, .pix_eof, .cur_luma, .ref_luma,
    .intra_mode, .scene_thr(scene_thr[15:0]), .min_gap, .fb_valid, .fb_true,
    .fb_target, .done(done_s), .chi_raw(chi_s), .est_sad(est_s), .scene_cut(cut_s)
  );

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cur_px(int cb, int cs, int i);
    return (cb + cs * i) & 255;
  endfunction
  function automatic int ref_px(int rb, int rs, int i);
    return (rb + ((i * rs) & 63)) & 255;
  endfunction

  function automatic longint model_chi(int cb, int cs, int rb, int rs, bit intra);
    longint acc = 0;
    for (int r = 0; r < NPIX / 16; r++) begin
      int d[16];
      int sum = 0, mean, amean, dev = 0;
      for (int k = 0; k < 16; k++) begin
        int i = r * 16 + k;
        d[k] = intra ? cur_px(cb, cs, i) : cur_px(cb, cs, i) - ref_px(rb, rs, i);
        sum += d[k];
      end
      mean  = sum >>> 4;
      amean = (mean < 0) ? -mean : mean;
      for (int k = 0; k < 16; k++) dev += (d[k] - mean < 0) ? mean - d[k] : d[k] - mean;
      acc += longint'(amean) * longint'(dev);
    end
    return acc;
  endfunction

  // sends a frame and returns in the cycle where done is high
  task automatic send_frame(int cb, int cs, int rb, int rs, bit intra);
    int t = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NPIX; i++) begin
      pix_valid  = 1'b1;
      pix_sof    = (i == 0);
      pix_eof    = (i == NPIX - 1);
      intra_mode = intra;
      cur_luma   = 8'(cur_px(cb, cs, i));
      ref_luma   = 8'(ref_px(rb, rs, i));
      @(negedge clk);
    end
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    while (!done && t < 40) begin
      @(negedge clk);
      t++;
    end
    nchk++;
    if (!done) begin
      nerr++;
      $display("FAIL R3: done not seen, got 0 expected 1");
    end
  endtask

  // frame plus all per-frame checks against the model
  task automatic frame_check(int cb, int cs, int rb, int rs, bit intra);
    longint chi, g, exp_cut;
    chi = model_chi(cb, cs, rb, rs, intra);
    g   = intra ? g_intra : g_inter;
    if (intra) exp_cut = 0;
    else       exp_cut = (chi > longint'(scene_thr) && gap_m >= int'(min_gap)) ? 1 : 0;
    send_frame(cb, cs, rb, rs, intra);
    chk(intra ? "R1 intra R2 R3 chi_raw" : "R1 inter R2 R3 chi_raw", longint'(chi_raw), chi);
    chk("R5 est_sad", longint'(est_sad), (g * chi) >>> 16);
    chk("R8 scene_cut", longint'(scene_cut), exp_cut);
    chk("R4 saturated chi_raw", longint'(chi_s), (chi > 65535) ? 65535 : chi);
    if (intra || exp_cut == 1) gap_m = 0;
    else if (gap_m < 255)      gap_m++;
    last_chi   = chi;
    last_intra = intra;
    // R3 one-cycle pulse
    @(negedge clk);
    chk("R3 done pulse width", longint'(done), 0);
  endtask

  task automatic send_fb(longint tru, longint tgt);
    @(negedge clk);
    fb_valid = 1'b1; fb_true = 32'(tru); fb_target = 32'(tgt);
    @(negedge clk);
    fb_valid = 1'b0;
    if (last_intra) begin
      if (tru != 0) g_intra = (g_intra * tgt) / tru;
      if (g_intra > 24'hFFFFFF) g_intra = 24'hFFFFFF;
    end else begin
      if (last_chi != 0) g_inter = (tru * 65536) / last_chi;
      if (g_inter > 24'hFFFFFF) g_inter = 24'hFFFFFF;
    end
    repeat (80) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    longint c2, ci;
    rst_n = 1'b0;
    pix_valid = 0; pix_sof = 0; pix_eof = 0; intra_mode = 0;
    cur_luma = 0; ref_luma = 0; fb_valid = 0; fb_true = 0; fb_target = 0;
    scene_thr = 40'd20000; min_gap = 8'd2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset done", longint'(done), 0);
    chk("R9 reset chi_raw", longint'(chi_raw), 0);
    chk("R9 reset est_sad", longint'(est_sad), 0);
    chk("R9 reset scene_cut", longint'(scene_cut), 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      frame_check(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                  int'(VEC[v][15:8]), VEC[v][0]);
    end

    // R9 outputs hold between frames
    repeat (20) @(negedge clk);
    chk("R9 hold chi_raw", longint'(chi_raw), last_chi);

    // R8 scene cut spacing: intra then inter frames with threshold 0
    scene_thr = 40'd0;
    frame_check(10, 3, 0, 0, 1);
    frame_check(200, 1, 20, 5, 0);
    frame_check(200, 1, 20, 5, 0);
    frame_check(200, 1, 20, 5, 0);
    chk("R8 cut after min_gap", longint'(scene_cut), 1);
    // R8 equal to threshold is not a cut
    c2 = model_chi(200, 1, 20, 5, 0);
    scene_thr = 40'(c2);
    frame_check(200, 1, 20, 5, 0);
    frame_check(200, 1, 20, 5, 0);
    frame_check(200, 1, 20, 5, 0);
    chk("R8 chi equal to threshold", longint'(scene_cut), 0);
    chk("R4 narrow accumulator reaches max", longint'(chi_s), (c2 > 65535) ? 65535 : c2);
    scene_thr = 40'hFF_FFFF_FFFF;

    // R6 inter gain refinement
    frame_check(200, 1, 20, 5, 0);
    send_fb(3 * c2, 0);
    frame_check(200, 1, 20, 5, 0);
    chk("R6 gain x3 estimate", longint'(est_sad), 3 * c2);
    // R6 zero complexity skips the update
    frame_check(50, 0, 50, 0, 0);
    send_fb(12345, 0);
    frame_check(200, 1, 20, 5, 0);
    chk("R6 zero chi keeps gain", longint'(est_sad), 3 * c2);
    // R6 saturation of the gain
    send_fb(32'hFFFF_FFFF, 0);
    frame_check(200, 1, 20, 5, 0);

    // R7 intra gain refinement
    ci = model_chi(10, 3, 0, 0, 1);
    frame_check(10, 3, 0, 0, 1);
    send_fb(2, 3);
    frame_check(10, 3, 0, 0, 1);
    chk("R7 intra gain 1.5", longint'(est_sad), (ci * 98304) >>> 16);
    // R7 zero true bits skip the update
    send_fb(0, 7);
    frame_check(10, 3, 0, 0, 1);
    chk("R7 zero true keeps gain", longint'(est_sad), (ci * 98304) >>> 16);
    // R1 intra ignores the reference samples
    frame_check(10, 3, 99, 13, 1);
    chk("R1 intra ignores ref", longint'(chi_raw), ci);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule